// File: doc/BRIEF.md
# Configurable Four-Bit Bidirectional Port Slice

This block is the logic of one four-bit general-purpose pin group. It holds an output data register and turns each stored bit into two pad controls: a pull-down enable and a pull-up (high-side) enable. Each bit is set separately to drive as an open-drain output or as an output with an internal pull-up. The level the register takes at reset is chosen once for the whole group. Software can write the group as one nibble or as a single bit. The pin levels are read back through a path that is gated off while the part is in hold.

Two power-saving states are handled. In halt the register is frozen and every output keeps its level. In hold all drive is removed and the input path is disabled. When hold ends, the outputs return from the register, which has not changed. Adjacent pins can also form an inverter pair, in which one pin's input level drives its partner pin's output, inverted. This pairing is honoured only when both pins are open-drain and the group resets high. Any other setting raises a configuration error for that pair, and the pair behaves as two ordinary port bits.

Top module: `gpio_slice`

## Requirements
- R1: While rst_n is low, the data register is loaded with all ones when rst_high is 1 and with all zeros when rst_high is 0, and the pins drive that level.
- R2: A bit with od_sel=1 (open-drain) never asserts pu_en. A stored 0 asserts pd_en, and a stored 1 releases the pin with both enables low.
- R3: A bit with od_sel=0 (pull-up) asserts pu_en for a stored 1 and pd_en for a stored 0. pd_en and pu_en of a pin are never both high.
- R4: wr_all loads all four bits from wr_data at the next clock edge. When wr_all and wr_bit are both high, wr_all takes priority.
- R5: wr_bit loads wr_val into bit wr_idx only, at the next clock edge. The other three bits are unchanged.
- R6: While halt is high, writes are ignored and every output keeps its level.
- R7: While hold is high, every pd_en and pu_en is low, rd_data and rd_bit read 0, and writes are ignored. When hold falls, the outputs return from the unchanged register with no write.
- R8: Outside hold, rd_data equals pad_in and rd_bit equals pad_in[rd_idx].
- R9: Pair p is made of pin 2p (input) and pin 2p+1 (output). When inv_en[p]=1, od_sel is 1 for both pins and rst_high=1, pin 2p drives nothing, pin 2p+1 has pd_en equal to pad_in[2p] and pu_en low, and this continues in halt.
- R10: When inv_en[p]=1 and the R9 conditions do not all hold, cfg_err[p] is 1 and both pins act as normal port bits. cfg_err[p] is 0 whenever inv_en[p]=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_high | input | 1 | Group reset level: 1 = high, 0 = low |
| od_sel | input | 4 | Per-bit output type: 1 = open-drain, 0 = pull-up |
| inv_en | input | 2 | Per-pair inverter request |
| halt | input | 1 | Halt mode flag |
| hold | input | 1 | Hold mode flag |
| wr_all | input | 1 | Group write strobe |
| wr_bit | input | 1 | Single-bit write strobe |
| wr_idx | input | 2 | Bit index for a single-bit write |
| wr_val | input | 1 | Value for a single-bit write |
| wr_data | input | 4 | Data for a group write |
| rd_idx | input | 2 | Bit index for single-bit read |
| pad_in | input | 4 | Pin levels seen at the pads |
| pd_en | output | 4 | Pull-down enables |
| pu_en | output | 4 | Pull-up / high-side enables |
| rd_data | output | 4 | Gated group read-back |
| rd_bit | output | 1 | Gated single-bit read-back |
| cfg_err | output | 2 | Per-pair illegal inverter configuration |

## Verification
Several rules are checked by the assertions on every cycle: an open-drain pin never pulls up, the two enables of a pin never clash, hold silences all drive and reads, the register stays still through halt and hold, and each active or faulty pair drives as required. Other behaviours can only be shown by the bench's scenarios: the priority between the two write strobes, which bit a single-bit write lands on, the outputs coming back when hold ends, and the move from a legal to an illegal inverter setting. The bench's reference model follows each of these cycle by cycle.

// File: rtl/gpio_slice_pkg.sv
package gpio_slice_pkg;

  typedef struct packed {
    logic pd;
    logic pu;
  } drive_t;

  // Plain port bit: a 0 pulls down; a 1 pulls up only on a pull-up bit.
  function automatic drive_t normal_drive(input logic q, input logic od);
    drive_t d;
    d.pd = ~q;
    d.pu = q & ~od;
    return d;
  endfunction

  // Inverter output pin: open-drain, pulls low while its source is high.
  function automatic drive_t inv_drive(input logic src);
    drive_t d;
    d.pd = src;
    d.pu = 1'b0;
    return d;
  endfunction

  function automatic logic inv_legal(input logic en, input logic od_in,
                                     input logic od_out, input logic rst_hi);
    return en & od_in & od_out & rst_hi;
  endfunction

endpackage

// File: rtl/gpio_slice_reg.sv
module gpio_slice_reg #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_high,
  input  logic          freeze,
  input  logic          wr_all,
  input  logic          wr_bit,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_val,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= {W{rst_high}};
    end else if (!freeze) begin
      if (wr_all) begin
        q <= wr_data;
      end else if (wr_bit) begin
        q[wr_idx] <= wr_val;
      end
    end
  end

endmodule

// File: rtl/gpio_slice_pair.sv
module gpio_slice_pair
  import gpio_slice_pkg::*;
(
  input  logic [1:0] q,
  input  logic [1:0] od,
  input  logic       inv_en,
  input  logic       rst_high,
  input  logic       pad_src,
  input  logic       hold,
  output logic [1:0] pd,
  output logic [1:0] pu,
  output logic       active,
  output logic       cfg_err
);

  drive_t da, db;

  always_comb begin
    active  = inv_legal(inv_en, od[0], od[1], rst_high);
    cfg_err = inv_en & ~active;
    da = normal_drive(q[0], od[0]);
    db = normal_drive(q[1], od[1]);
    if (active) begin
      da = '0;
      db = inv_drive(pad_src);
    end
    if (hold) begin
      da = '0;
      db = '0;
    end
    pd = {db.pd, da.pd};
    pu = {db.pu, da.pu};
  end

endmodule

// File: rtl/gpio_slice_rd.sv
module gpio_slice_rd #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic [W-1:0]  pad_in,
  input  logic          hold,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic          rd_bit
);

  logic [W-1:0] gated;

  always_comb begin
    gated   = hold ? '0 : pad_in;
    rd_data = gated;
    rd_bit  = gated[rd_idx];
  end

endmodule

// File: rtl/gpio_slice.sv
module gpio_slice #(
  parameter int W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rst_high,
  input  logic [W-1:0]           od_sel,
  input  logic [W/2-1:0]         inv_en,
  input  logic                   halt,
  input  logic                   hold,
  input  logic                   wr_all,
  input  logic                   wr_bit,
  input  logic [$clog2(W)-1:0]   wr_idx,
  input  logic                   wr_val,
  input  logic [W-1:0]           wr_data,
  input  logic [$clog2(W)-1:0]   rd_idx,
  input  logic [W-1:0]           pad_in,
  output logic [W-1:0]           pd_en,
  output logic [W-1:0]           pu_en,
  output logic [W-1:0]           rd_data,
  output logic                   rd_bit,
  output logic [W/2-1:0]         cfg_err
);

  localparam int NPAIR = W / 2;
  localparam int IW    = $clog2(W);

  logic [W-1:0]     q_w;
  logic [NPAIR-1:0] pair_act;
  logic             freeze_w;

  assign freeze_w = halt | hold;

  gpio_slice_reg #(.W(W), .IW(IW)) u_reg (
    .clk(clk), .rst_n(rst_n), .rst_high(rst_high), .freeze(freeze_w),
    .wr_all(wr_all), .wr_bit(wr_bit), .wr_idx(wr_idx), .wr_val(wr_val),
    .wr_data(wr_data), .q(q_w)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    gpio_slice_pair u_pair (
      .q(q_w[2*p+1:2*p]), .od(od_sel[2*p+1:2*p]), .inv_en(inv_en[p]),
      .rst_high(rst_high), .pad_src(pad_in[2*p]), .hold(hold),
      .pd(pd_en[2*p+1:2*p]), .pu(pu_en[2*p+1:2*p]),
      .active(pair_act[p]), .cfg_err(cfg_err[p])
    );
  end

  gpio_slice_rd #(.W(W), .IW(IW)) u_rd (
    .pad_in(pad_in), .hold(hold), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_bit(rd_bit)
  );

endmodule

// File: rtl/gpio_slice_chk.sv
module gpio_slice_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rst_high,
  input logic [W-1:0]   od_sel,
  input logic           halt,
  input logic           hold,
  input logic [W-1:0]   pad_in,
  input logic [W-1:0]   pd_en,
  input logic [W-1:0]   pu_en,
  input logic [W-1:0]   rd_data,
  input logic           rd_bit,
  input logic [W/2-1:0] cfg_err,
  input logic [W-1:0]   q_w,
  input logic [W/2-1:0] pair_act
);

  AST_RESET_LEVEL: assert property (@(posedge clk)
    !rst_n |=> (q_w == {W{$past(rst_high)}})); // R1

  AST_OD_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & od_sel) == '0); // R2

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & pd_en) == '0); // R3

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> $stable(q_w)); // R6

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (pd_en == '0 && pu_en == '0 && rd_data == '0 && !rd_bit)); // R7

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> $stable(q_w)); // R7

  AST_READ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (rd_data == pad_in)); // R8

  for (genvar p = 0; p < W/2; p++) begin : g_pchk
    AST_INV_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_act[p] && !hold) |->
        (pd_en[2*p+1] == pad_in[2*p] && !pu_en[2*p+1] &&
         !pd_en[2*p] && !pu_en[2*p])); // R9

    AST_ERR_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err[p] && !hold) |->
        (pd_en[2*p] == !q_w[2*p] && pd_en[2*p+1] == !q_w[2*p+1])); // R10
  end

endmodule

bind gpio_slice gpio_slice_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_high(rst_high), .od_sel(od_sel),
  .halt(halt), .hold(hold), .pad_in(pad_in), .pd_en(pd_en), .pu_en(pu_en),
  .rd_data(rd_data), .rd_bit(rd_bit), .cfg_err(cfg_err),
  .q_w(q_w), .pair_act(pair_act)
);

// File: tb/gpio_slice_test.sv
module gpio_slice_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_high = 1'b1;
  logic [3:0] od_sel = 4'b0000;
  logic [1:0] inv_en = 2'b00;
  logic       halt = 1'b0, hold = 1'b0;
  logic       wr_all = 1'b0, wr_bit = 1'b0, wr_val = 1'b0;
  logic [1:0] wr_idx = 2'd0, rd_idx = 2'd0;
  logic [3:0] wr_data = 4'h0, pad_in = 4'h0;
  logic [3:0] pd_en, pu_en, rd_data;
  logic       rd_bit;
  logic [1:0] cfg_err;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R1";
  int    mq[4];

  always #4 clk = ~clk;

  gpio_slice uut (
    .clk(clk), .rst_n(rst_n), .rst_high(rst_high), .od_sel(od_sel),
    .inv_en(inv_en), .halt(halt), .hold(hold), .wr_all(wr_all),
    .wr_bit(wr_bit), .wr_idx(wr_idx), .wr_val(wr_val), .wr_data(wr_data),
    .rd_idx(rd_idx), .pad_in(pad_in), .pd_en(pd_en), .pu_en(pu_en),
    .rd_data(rd_data), .rd_bit(rd_bit), .cfg_err(cfg_err)
  );

  function automatic bit pair_ok(int p);
    return inv_en[p] && od_sel[2*p] && od_sel[2*p+1] && rst_high;
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) mq[i] = rst_high;
    end else if (!halt && !hold) begin
      if (wr_all) begin
        for (int i = 0; i < 4; i++) mq[i] = wr_data[i];
      end else if (wr_bit) begin
        mq[wr_idx] = wr_val;
      end
    end
  endtask

  task automatic compare();
    logic [3:0] epd, epu, erd;
    logic [1:0] eerr;
    logic       erb;
    for (int i = 0; i < 4; i++) begin
      int p = i / 2;
      epd[i] = 1'b0;
      epu[i] = 1'b0;
      if (hold) begin
        // all off
      end else if (pair_ok(p)) begin
        if (i % 2 == 1) epd[i] = pad_in[i-1];
      end else begin
        epd[i] = (mq[i] == 0);
        epu[i] = (mq[i] == 1) && !od_sel[i];
      end
    end
    for (int p = 0; p < 2; p++) eerr[p] = inv_en[p] && !pair_ok(p);
    erd = hold ? 4'h0 : pad_in;
    erb = erd[rd_idx];
    checks++;
    if (pd_en !== epd || pu_en !== epu || rd_data !== erd ||
        rd_bit !== erb || cfg_err !== eerr) begin
      errors++;
      $display("FAIL %s t=%0t actual pd=%b pu=%b rd=%b rb=%b err=%b expected pd=%b pu=%b rd=%b rb=%b err=%b",
               cur_req, $time, pd_en, pu_en, rd_data, rd_bit, cfg_err,
               epd, epu, erd, erb, eerr);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input logic lvl);
    cur_req = "R1";
    rst_high = lvl;
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    do_reset(1'b1);                       // R1 high level
    od_sel = 4'b0101;
    step();

    cur_req = "R4";                       // R4 group writes
    foreach (wr_data[k]) ;
    wr_all = 1'b1;
    wr_data = 4'b0110; step();
    wr_data = 4'b1001; step();
    wr_data = 4'b0000; step();
    cur_req = "R4";                       // R4 priority over bit write
    wr_bit = 1'b1; wr_idx = 2'd1; wr_val = 1'b1; wr_data = 4'b1010;
    step();
    wr_all = 1'b0;

    cur_req = "R5";                       // R5 single-bit writes
    for (int i = 0; i < 4; i++) begin
      wr_idx = i[1:0]; wr_val = i[0];
      step();
    end
    wr_bit = 1'b0;

    cur_req = "R2";                       // R2 open-drain bits
    od_sel = 4'b1111; step();
    wr_all = 1'b1; wr_data = 4'b1100; step(); wr_all = 1'b0; step();
    cur_req = "R3";                       // R3 pull-up bits
    od_sel = 4'b0000; step();
    od_sel = 4'b0011; step();

    cur_req = "R6";                       // R6 halt freezes outputs
    halt = 1'b1;
    wr_all = 1'b1; wr_data = 4'b0011; step();
    wr_all = 1'b0; wr_bit = 1'b1; wr_idx = 2'd3; wr_val = 1'b0; step();
    wr_bit = 1'b0; step();
    halt = 1'b0; step();

    cur_req = "R7";                       // R7 hold silences and restores
    pad_in = 4'b1011;
    hold = 1'b1; step();
    wr_all = 1'b1; wr_data = 4'b0101; step();
    wr_all = 1'b0; rd_idx = 2'd3; step();
    hold = 1'b0; step(); step();

    cur_req = "R8";                       // R8 read path
    for (int v = 0; v < 16; v += 5) begin
      pad_in = v[3:0];
      for (int j = 0; j < 4; j++) begin
        rd_idx = j[1:0];
        step();
      end
    end

    cur_req = "R9";                       // R9 legal inverter pairs
    od_sel = 4'b1111; inv_en = 2'b11;
    for (int v = 0; v < 16; v += 3) begin
      pad_in = v[3:0];
      step();
    end
    halt = 1'b1; pad_in = 4'b0100; step(); pad_in = 4'b0001; step();
    halt = 1'b0;
    hold = 1'b1; step(); hold = 1'b0; step();

    cur_req = "R10";                      // R10 illegal pairs fall back
    od_sel = 4'b0111; step();
    inv_en = 2'b10; step();
    inv_en = 2'b00; step();
    do_reset(1'b0);                       // R1 low level
    cur_req = "R10";
    od_sel = 4'b1111; inv_en = 2'b11; pad_in = 4'b0101; step();
    wr_all = 1'b1; wr_data = 4'b1010; step(); wr_all = 1'b0; step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule